// File: doc/BRIEF.md
# ECC Write Error Injector

This block sits in a RAM controller's write path, right after the SECDED encoder. It can corrupt a codeword on purpose so that the detection and correction logic further down can be tested. The encoder computes the data and check bits as usual. The block then inverts chosen bits of that codeword before it reaches the array. There are four inject modes: single-bit or double-bit, and each of those either continuous or one-shot. The bit to invert is set by a programmable position field.

Software sets the modes through one 16-bit control word on a simple register port. The port has a write enable and write data, and the read data is always available. The codeword path is combinational. Only the control word and two one-shot "armed" flags hold state. A one-shot mode fires only after its control bit changes from 0 to 1. Writing 1 to a bit that is already 1 does not re-arm it.

The codeword is arranged as data in bits `[DATA_W-1:0]`, check bits above the data, and the overall odd-parity bit at `CW_W-1`, where `CW_W = DATA_W + CHK_W + 1`.

Top module: `ecc_wr_injector`

## Requirements
- R1: After reset, `regRdData` reads 0 and every write passes through unchanged. Reset is asynchronous and active low.
- R2: Control word layout, with bit 0 as the LSB:
  - bit 13: continuous single-bit mode
  - bit 12: one-shot single-bit mode
  - bit 9: continuous double-bit mode
  - bit 8: one-shot double-bit mode
  - bits 7:0: flip position
  - bits 15:14 and 11:10 read 0 and ignore writes.
  - A register write shows on `regRdData` from the next cycle.
- R3: While bit 13 is set and the flip position is below `CW_W`, every `wrStrobe` cycle inverts exactly that one codeword bit.
- R4: In one-shot single-bit mode (bit 12), the bit at the flip position is inverted on the first `wrStrobe` cycle after the bit was written from 0 to 1, counted from the cycle after that register write. Later strobes pass the codeword through unchanged.
- R5: An armed one-shot re-arms only through the sequence below. Clearing the control bit also drops a pending arm.
  - Writing 1 over a 1 has no effect.
  - Writing 0 and then 1 re-arms it.
- R6: While bit 9 is set and the position is in range, every strobe inverts two bits: the selected bit and the parity bit `CW_W-1`.
- R7: If a double-bit mode and a single-bit mode are active on the same strobe, the double-bit inversion wins.
- R8: If the flip position is `CW_W` or above, no bit is inverted, the parity bit included.
- R9: When `wrStrobe` is low, `cwOut` equals `cwIn` within the same cycle, whatever the control word holds.
- R10: One-shot double-bit mode (bit 8) inverts the selected bit and the parity bit on the first strobe only, and it is armed the same way as R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Writes the control word |
| regWrData | input | 16 | New control word |
| regRdData | output | 16 | Current control word |
| wrStrobe | input | 1 | A memory write happens this cycle |
| cwIn | input | CW_W | Encoded codeword from the ECC generator |
| cwOut | output | CW_W | Codeword driven to the array |

## Verification
The stimulus uses three codewords:
- **All-zero:** exposes exactly which bits flip.
- **All-one:** shows that a flip clears a bit rather than setting it.
- **Mixed:** catches masks that are shifted or wrong in polarity.

Each mode runs over runs of back-to-back strobes, which separates continuous from one-shot behaviour. Register writes fall on the same cycle as a strobe, which checks that a new value takes effect one cycle later. The position is walked across three cases:
- the parity bit itself
- the first value out of range
- 255

The register sequences cover:
- a set over an already-set bit
- clear then set
- clear before use

Together these separate correct edge arming from level arming and from a stale armed flag.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int REG_W = 16;
  localparam int POS_W = 8;

  // control word bit positions (LSB = 0)
  localparam int CONT_SGL_BIT = 13;
  localparam int ONE_SGL_BIT  = 12;
  localparam int CONT_DBL_BIT = 9;
  localparam int ONE_DBL_BIT  = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic             flipSel;
    logic             flipPar;
    logic [POS_W-1:0] pos;
  } injCmd_t;
endpackage

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
  import ecc_inj_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             wrStrobe,
  output injCmd_t          cmd
);
  localparam int NSHOT = 2;  // lane 0 single-bit, lane 1 double-bit

  logic             contSgl, contDbl;
  logic [POS_W-1:0] flipPos;
  logic [NSHOT-1:0] shotBit, shotNxt, armed;

  assign shotNxt[0] = regWrEn ? regWrData[ONE_SGL_BIT] : shotBit[0];
  assign shotNxt[1] = regWrEn ? regWrData[ONE_DBL_BIT] : shotBit[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      contSgl <= 1'b0;
      contDbl <= 1'b0;
      flipPos <= '0;
    end else if (regWrEn) begin
      contSgl <= regWrData[CONT_SGL_BIT];
      contDbl <= regWrData[CONT_DBL_BIT];
      flipPos <= regWrData[POS_W-1:0];
    end
  end

  for (genvar g = 0; g < NSHOT; g++) begin : gShot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shotBit[g] <= 1'b0;
        armed[g]   <= 1'b0;
      end else begin
        shotBit[g] <= shotNxt[g];
        // arm on a 0->1 edge, drop on use or when the bit is cleared
        armed[g]   <= (shotNxt[g] & ~shotBit[g]) |
                      (armed[g] & shotNxt[g] & ~wrStrobe);
      end
    end
  end

  always_comb begin
    regRdData               = '0;
    regRdData[CONT_SGL_BIT] = contSgl;
    regRdData[ONE_SGL_BIT]  = shotBit[0];
    regRdData[CONT_DBL_BIT] = contDbl;
    regRdData[ONE_DBL_BIT]  = shotBit[1];
    regRdData[POS_W-1:0]    = flipPos;
  end

  logic sglAct, dblAct;
  assign sglAct = contSgl | armed[0];
  assign dblAct = contDbl | armed[1];

  always_comb begin
    cmd.flipSel = wrStrobe & (sglAct | dblAct);
    cmd.flipPar = wrStrobe & dblAct;  // double-bit mode overrides single-bit
    cmd.pos     = flipPos;
  end
endmodule

// File: rtl/ecc_inj_path.sv
module ecc_inj_path
  import ecc_inj_pkg::*;
#(
  parameter int CW_W = 40
) (
  input  injCmd_t         cmd,
  input  logic [CW_W-1:0] cwIn,
  output logic [CW_W-1:0] cwOut
);
  localparam int PAR_IDX = CW_W - 1;

  logic            inRange;
  logic [CW_W-1:0] flipMask;

  assign inRange = 32'(cmd.pos) < CW_W;

  for (genvar i = 0; i < CW_W; i++) begin : gMask
    assign flipMask[i] = inRange &
                         ((cmd.flipSel & (32'(cmd.pos) == i)) |
                          (cmd.flipPar & (i == PAR_IDX)));
  end

  assign cwOut = cwIn ^ flipMask;
endmodule

// File: rtl/ecc_wr_injector.sv
module ecc_wr_injector
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 7,
  localparam int CW_W  = DATA_W + CHK_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             wrStrobe,
  input  logic [CW_W-1:0]  cwIn,
  output logic [CW_W-1:0]  cwOut
);
  injCmd_t injCmd;

  ecc_inj_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .wrStrobe  (wrStrobe),
    .cmd       (injCmd)
  );

  ecc_inj_path #(.CW_W(CW_W)) u_path (
    .cmd   (injCmd),
    .cwIn  (cwIn),
    .cwOut (cwOut)
  );
endmodule

// File: rtl/ecc_wr_injector_chk.sv
module ecc_wr_injector_chk #(
  parameter int CW_W = 40
) (
  input logic            clk,
  input logic            rstN,
  input logic            regWrEn,
  input logic [15:0]     regWrData,
  input logic [15:0]     regRdData,
  input logic            wrStrobe,
  input logic [CW_W-1:0] cwIn,
  input logic [CW_W-1:0] cwOut
);
  logic       pastOk;
  logic [7:0] pos;
  logic       inR;

  assign pos = regRdData[7:0];
  assign inR = 32'(pos) < CW_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R9
  a_r9_idle_pass: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> cwOut == cwIn);

  // R8
  a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !inR) |-> cwOut == cwIn);

  // R3
  a_r3_cont_single: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && inR && regRdData[13] && regRdData[9:8] == 2'b00) |->
      ($countones(cwOut ^ cwIn) == 1 && cwOut[pos] != cwIn[pos]));

  // R6
  a_r6_cont_double: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && inR && regRdData[9] && 32'(pos) != CW_W - 1) |->
      ($countones(cwOut ^ cwIn) == 2 && cwOut[CW_W-1] != cwIn[CW_W-1]
       && cwOut[pos] != cwIn[pos]));

  // R4, R10: a second strobe in a row, with no arming write between, changes nothing
  a_r4_shot_once: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && wrStrobe && $past(wrStrobe) && !$past(regWrEn)
     && !regRdData[13] && !regRdData[9]) |-> cwOut == cwIn);
endmodule

bind ecc_wr_injector ecc_wr_injector_chk #(.CW_W(CW_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .wrStrobe  (wrStrobe),
  .cwIn      (cwIn),
  .cwOut     (cwOut)
);

// File: tb/tb_ecc_wr_injector.sv
`timescale 1ns/1ps
module tb_ecc_wr_injector;
  localparam int CW = 40;
  localparam logic [CW-1:0] C1 = 40'h00_0000_0000;
  localparam logic [CW-1:0] C2 = 40'hFF_FFFF_FFFF;
  localparam logic [CW-1:0] C3 = 40'h5A_A5F0_0F33;
  localparam int NV = 33;
  // {req[3:0], regWr, regVal[15:0], strobe, cwIn[39:0], expOut[39:0]}
  localparam logic [101:0] VEC [NV] = '{
    {4'd2,  1'b1, 16'h2005, 1'b1, C1, C1},                 // R2 new value not yet active
    {4'd3,  1'b0, 16'h0000, 1'b1, C1, 40'h00_0000_0020},   // R3
    {4'd3,  1'b0, 16'h0000, 1'b1, C2, 40'hFF_FFFF_FFDF},   // R3
    {4'd9,  1'b0, 16'h0000, 1'b0, C3, C3},                 // R9
    {4'd3,  1'b1, 16'h0000, 1'b1, C1, 40'h00_0000_0020},   // R3
    {4'd9,  1'b1, 16'h1007, 1'b0, C1, C1},                 // R9
    {4'd4,  1'b0, 16'h0000, 1'b1, C1, 40'h00_0000_0080},   // R4
    {4'd4,  1'b0, 16'h0000, 1'b1, C1, C1},                 // R4
    {4'd5,  1'b1, 16'h1007, 1'b0, C1, C1},                 // R5
    {4'd5,  1'b0, 16'h0000, 1'b1, C1, C1},                 // R5 no rearm
    {4'd5,  1'b1, 16'h0000, 1'b0, C1, C1},                 // R5
    {4'd5,  1'b1, 16'h1007, 1'b0, C1, C1},                 // R5
    {4'd5,  1'b0, 16'h0000, 1'b1, C2, 40'hFF_FFFF_FF7F},   // R5 rearmed
    {4'd9,  1'b1, 16'h0203, 1'b0, C1, C1},                 // R9
    {4'd6,  1'b0, 16'h0000, 1'b1, C1, 40'h80_0000_0008},   // R6
    {4'd6,  1'b0, 16'h0000, 1'b1, C3, 40'hDA_A5F0_0F3B},   // R6
    {4'd9,  1'b1, 16'h2203, 1'b0, C1, C1},                 // R9
    {4'd7,  1'b0, 16'h0000, 1'b1, C1, 40'h80_0000_0008},   // R7
    {4'd9,  1'b1, 16'h0000, 1'b0, C1, C1},                 // R9
    {4'd9,  1'b1, 16'h0122, 1'b0, C1, C1},                 // R9
    {4'd10, 1'b0, 16'h0000, 1'b1, C1, 40'h84_0000_0000},   // R10
    {4'd10, 1'b0, 16'h0000, 1'b1, C1, C1},                 // R10
    {4'd9,  1'b1, 16'h2028, 1'b0, C3, C3},                 // R9
    {4'd8,  1'b0, 16'h0000, 1'b1, C3, C3},                 // R8 pos 40
    {4'd9,  1'b1, 16'h20FF, 1'b0, C2, C2},                 // R9
    {4'd8,  1'b0, 16'h0000, 1'b1, C2, C2},                 // R8 pos 255
    {4'd9,  1'b1, 16'h2027, 1'b0, C1, C1},                 // R9
    {4'd3,  1'b0, 16'h0000, 1'b1, C1, 40'h80_0000_0000},   // R3 parity position
    {4'd9,  1'b1, 16'h1004, 1'b0, C1, C1},                 // R9
    {4'd9,  1'b1, 16'h0000, 1'b0, C1, C1},                 // R9
    {4'd5,  1'b0, 16'h0000, 1'b1, C1, C1},                 // R5 cleared arm dropped
    {4'd9,  1'b1, 16'h1004, 1'b0, C3, C3},                 // R9
    {4'd4,  1'b0, 16'h0000, 1'b1, C3, 40'h5A_A5F0_0F23}    // R4
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [15:0]   regWrData = '0;
  logic [15:0]   regRdData;
  logic          wrStrobe = 1'b0;
  logic [CW-1:0] cwIn = '0;
  logic [CW-1:0] cwOut;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ecc_wr_injector dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .wrStrobe(wrStrobe), .cwIn(cwIn), .cwOut(cwOut)
  );

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    wrStrobe = 1'b1; cwIn = C2;
    #2;
    chk("R1 reset readback", 40'(regRdData), 40'h0);
    chk("R1 reset passthrough", cwOut, C2);
    rstN = 1'b1;
    wrStrobe = 1'b0;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      regWrEn   = VEC[k][97];
      regWrData = VEC[k][96:81];
      wrStrobe  = VEC[k][80];
      cwIn      = VEC[k][79:40];
      #2;
      chk($sformatf("R%0d step %0d", VEC[k][101:98], k), cwOut, VEC[k][39:0]);
    end
    // R2 reserved bits ignored
    @(negedge clk); regWrEn = 1'b1; regWrData = 16'hFFFF; wrStrobe = 1'b0;
    @(negedge clk); regWrEn = 1'b0; #2;
    chk("R2 reserved read zero", 40'(regRdData), 40'h33FF);
    // R2 layout, bit 13 and position
    @(negedge clk); regWrEn = 1'b1; regWrData = 16'h2004;
    @(negedge clk); regWrEn = 1'b0; wrStrobe = 1'b1; cwIn = C1; #2;
    chk("R2 readback", 40'(regRdData), 40'h2004);
    chk("R2 position field", cwOut, 40'h00_0000_0010);
    // R1 reset during operation
    @(negedge clk); rstN = 1'b0; #2;
    chk("R1 mid reset readback", 40'(regRdData), 40'h0);
    chk("R1 mid reset passthrough", cwOut, C1);
    @(negedge clk); rstN = 1'b1; #2;
    chk("R1 after reset passthrough", cwOut, C1);
    @(negedge clk); wrStrobe = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule